// File: doc/BRIEF.md
# Timer Compare Channel with Period-Reset Event

This block is one output-compare channel for a 16-bit timer subsystem. Software writes a compare value and a small control word. Every clock cycle the channel checks the compare value for equality against the count of one of two external timers, chosen by a select bit in the control word. When it finds a match, it updates an internal compare output latch according to the 4-bit mode field and raises a sticky interrupt flag.

In the period-reset mode, a match pulses a reset line to the selected timer. The compare value then works as that timer's period register. This reset path never touches any overflow flag of the timer. A channel built as the second instance (`SECOND_CH = 1`) can also pulse an ADC conversion start in the same cycle, but only while the external ADC-enable input is high.

The pin is driven from the latch only while the external direction input selects output. When the direction input selects input, the latch keeps updating in the background.

Top module: `cmp_event_unit`

## Requirements
- R1: The compare value (write address 1, 16 bits) is checked for equality against timer A's count when control bit 4 is 0, and against timer B's count when control bit 4 is 1. The count of the timer that is not selected has no effect.
- R2: In mode code 4'b1000 (control bits [3:0]), a match sets the compare latch to 1 at the next clock edge.
- R3: In mode code 4'b1001, a match clears the compare latch to 0 at the next clock edge.
- R4: In mode code 4'b0010, a match inverts the compare latch at the next clock edge.
- R5: In mode code 4'b1010, a match sets only the interrupt flag. The latch keeps its value and neither timer reset pulses.
- R6: In mode code 4'b1011, a match produces a one-cycle reset pulse on the selected timer's reset output only, at the next clock edge. The latch keeps its value.
- R7: In mode code 4'b1011, `adc_start` pulses together with the timer reset only if `SECOND_CH` is 1 and `adc_enable` was high in the match cycle. Otherwise it stays low.
- R8: A match in any of the five valid modes sets `irq_flag`. The flag stays set until a `flag_clr` pulse. If `flag_clr` and a match occur in the same cycle, the flag stays set.
- R9: A match fires once, in the first cycle of equality. A count that stays equal does not fire again until the equality has gone false.
- R10: Writing all-zero data to the control register (address 0) forces the compare latch to 0. Writing any other value does not. Mode codes other than the five listed produce no latch action and no flag.
- R11: `pin_oe` follows `pin_dir_out`. `pin_o` shows the latch only while `pin_oe` is 1 and is 0 otherwise. The latch updates on matches even while the pin is not driven.
- R12: After reset the latch, the flag, the mode, the select bit, the compare value, both timer resets and `adc_start` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control word, 1 = compare value |
| wr_data | input | 16 | Write data; control uses bits [4:0] |
| flag_clr | input | 1 | Pulse to clear the interrupt flag |
| tmr_a_cnt | input | 16 | Timer A count |
| tmr_b_cnt | input | 16 | Timer B count |
| adc_enable | input | 1 | ADC enabled; gates the conversion start |
| pin_dir_out | input | 1 | Direction bit, 1 = pin is an output |
| tmr_a_rst | output | 1 | One-cycle reset pulse to timer A |
| tmr_b_rst | output | 1 | One-cycle reset pulse to timer B |
| adc_start | output | 1 | One-cycle ADC conversion start pulse |
| pin_o | output | 1 | Pin value (latch gated by output enable) |
| pin_oe | output | 1 | Pin output enable |
| irq_flag | output | 1 | Sticky compare interrupt flag |

## Verification
The hardest situations to reach are collisions inside a single cycle: a flag clear landing on the same edge as a match, and a latch update made while the pin is in input direction, which cannot be seen directly. The bench drives the timer counts as plain inputs, so it can place a match on an exact edge together with the clear pulse. It reveals the hidden latch by turning the direction bit back to output after the match. A count held stalled on the compare value, and a second instance built with the second-channel parameter off, cover re-triggering and the ADC strobe gating.

// File: rtl/cmp_event_pkg.sv
// Package: shared widths, mode codes and control word layout for the
// compare channel. Assumes exactly two selectable timers.
package cmp_event_pkg;
    localparam int CNT_W   = 16;
    localparam int NUM_TMR = 2;
    localparam int ADDR_W  = 1;
    localparam int MODE_W  = 4;

    localparam logic [ADDR_W-1:0] ADR_CTL = 1'b0;
    localparam logic [ADDR_W-1:0] ADR_CMP = 1'b1;

    typedef enum logic [MODE_W-1:0] {
        CM_OFF = 4'b0000,
        CM_TGL = 4'b0010,
        CM_SET = 4'b1000,
        CM_CLR = 4'b1001,
        CM_SWI = 4'b1010,
        CM_SEV = 4'b1011
    } cmp_mode_e;

    typedef struct packed {
        logic                 tsel;
        logic [MODE_W-1:0]    mode;
    } cmp_ctl_t;

    localparam int CTL_W = $bits(cmp_ctl_t);
endpackage

// File: rtl/cmp_ctrl_regs.sv
// Control and compare registers. Decodes the write port and flags a write
// of all-zero data to the control word. Assumes single-cycle write strobes.
module cmp_ctrl_regs
    import cmp_event_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output cmp_ctl_t          ctl,
    output logic [W-1:0]      cmp_val,
    output logic              zero_wr
);
    logic ctl_we;
    logic cmp_we;

    // Address decode for both registers.
    always_comb begin
        ctl_we  = wr_en && (wr_addr == ADR_CTL);
        cmp_we  = wr_en && (wr_addr == ADR_CMP);
        zero_wr = ctl_we && (wr_data == '0);
    end

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl <= '0;
        else if (ctl_we) ctl <= cmp_ctl_t'(wr_data[CTL_W-1:0]);
    end

    // Compare value storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_val <= '0;
        else if (cmp_we) cmp_val <= wr_data;
    end
endmodule

// File: rtl/cmp_match_det.sv
// Selects one timer count and produces a single-cycle match pulse on the
// first cycle of equality with the compare value (rising-edge qualified).
module cmp_match_det
    import cmp_event_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int NT = NUM_TMR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NT*W-1:0] cnt_flat,
    input  logic            tsel,
    input  logic [W-1:0]    cmp_val,
    output logic            match
);
    logic [W-1:0] cnt_arr [NT];
    logic [W-1:0] sel_cnt;
    logic         eq_now;
    logic         eq_q;

    for (genvar i = 0; i < NT; i++) begin : g_unpack
        assign cnt_arr[i] = cnt_flat[i*W +: W];
    end

    // Timer mux and equality compare.
    always_comb begin
        sel_cnt = cnt_arr[tsel];
        eq_now  = (sel_cnt == cmp_val);
        match   = eq_now && !eq_q;
    end

    // Previous-cycle equality for edge qualification.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq_now;
    end
endmodule

// File: rtl/cmp_action.sv
// Applies the mode action on a match: latch update, sticky flag, timer
// reset pulses and the optional ADC start. Assumes match is one cycle.
module cmp_action
    import cmp_event_pkg::*;
#(
    parameter int NT        = NUM_TMR,
    parameter bit SECOND_CH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match,
    input  logic [MODE_W-1:0] mode,
    input  logic              tsel,
    input  logic              zero_wr,
    input  logic              flag_clr,
    input  logic              adc_enable,
    output logic              latch,
    output logic              flag,
    output logic [NT-1:0]     tmr_rst,
    output logic              adc_start
);
    logic valid_mode;
    logic sev_hit;

    // Mode classification for the current match.
    always_comb begin
        unique case (mode)
            CM_SET, CM_CLR, CM_TGL, CM_SWI, CM_SEV: valid_mode = 1'b1;
            default:                                valid_mode = 1'b0;
        endcase
        sev_hit = match && (mode == CM_SEV);
    end

    // Compare output latch; a zero control write wins over a match.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch <= 1'b0;
        else if (zero_wr) latch <= 1'b0;
        else if (match) begin
            case (mode)
                CM_SET:  latch <= 1'b1;
                CM_CLR:  latch <= 1'b0;
                CM_TGL:  latch <= ~latch;
                default: latch <= latch;
            endcase
        end
    end

    // Sticky interrupt flag; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   flag <= 1'b0;
        else if (match && valid_mode) flag <= 1'b1;
        else if (flag_clr)            flag <= 1'b0;
    end

    for (genvar i = 0; i < NT; i++) begin : g_rst
        // One-cycle reset pulse to the selected timer.
        always_ff @(posedge clk) begin
            if (!rst_n) tmr_rst[i] <= 1'b0;
            else        tmr_rst[i] <= sev_hit && (tsel == i[0]);
        end
    end

    if (SECOND_CH) begin : g_adc
        // Conversion start, gated by the ADC-enable input.
        always_ff @(posedge clk) begin
            if (!rst_n) adc_start <= 1'b0;
            else        adc_start <= sev_hit && adc_enable;
        end
    end else begin : g_no_adc
        logic unused_adc;
        assign unused_adc = adc_enable;
        assign adc_start  = 1'b0;
    end
endmodule

// File: rtl/cmp_event_unit.sv
// Top of the compare channel: register port, timer select and match
// detection, action logic and pin gating. Assumes timers count synchronously.
module cmp_event_unit
    import cmp_event_pkg::*;
#(
    parameter bit SECOND_CH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              flag_clr,
    input  logic [CNT_W-1:0]  tmr_a_cnt,
    input  logic [CNT_W-1:0]  tmr_b_cnt,
    input  logic              adc_enable,
    input  logic              pin_dir_out,
    output logic              tmr_a_rst,
    output logic              tmr_b_rst,
    output logic              adc_start,
    output logic              pin_o,
    output logic              pin_oe,
    output logic              irq_flag
);
    cmp_ctl_t             ctl;
    logic [CNT_W-1:0]     cmp_val;
    logic                 zero_wr;
    logic                 match;
    logic                 latch;
    logic [NUM_TMR-1:0]   rst_vec;

    cmp_ctrl_regs #(.W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctl     (ctl),
        .cmp_val (cmp_val),
        .zero_wr (zero_wr)
    );

    cmp_match_det #(.W(CNT_W), .NT(NUM_TMR)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_flat ({tmr_b_cnt, tmr_a_cnt}),
        .tsel     (ctl.tsel),
        .cmp_val  (cmp_val),
        .match    (match)
    );

    cmp_action #(.NT(NUM_TMR), .SECOND_CH(SECOND_CH)) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .match      (match),
        .mode       (ctl.mode),
        .tsel       (ctl.tsel),
        .zero_wr    (zero_wr),
        .flag_clr   (flag_clr),
        .adc_enable (adc_enable),
        .latch      (latch),
        .flag       (irq_flag),
        .tmr_rst    (rst_vec),
        .adc_start  (adc_start)
    );

    // Pin gating and reset fan-out.
    always_comb begin
        pin_oe    = pin_dir_out;
        pin_o     = pin_dir_out & latch;
        tmr_a_rst = rst_vec[0];
        tmr_b_rst = rst_vec[1];
    end
endmodule

// File: rtl/cmp_event_unit_chk.sv
// Port-level property checker for the compare channel, bound to every
// instance of the top module.
module cmp_event_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_addr,
    input logic [15:0] wr_data,
    input logic        flag_clr,
    input logic        adc_enable,
    input logic        tmr_a_rst,
    input logic        tmr_b_rst,
    input logic        adc_start,
    input logic        pin_o,
    input logic        irq_flag
);
    // R6: at most one timer reset at a time.
    p_rst_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tmr_a_rst, tmr_b_rst}));

    // R6: timer A reset lasts one cycle.
    p_rst_a_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_a_rst |=> !tmr_a_rst);

    // R6: timer B reset lasts one cycle.
    p_rst_b_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_b_rst |=> !tmr_b_rst);

    // R7: conversion start only together with a timer reset.
    p_adc_with_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (tmr_a_rst || tmr_b_rst));

    // R7: conversion start only when ADC was enabled in the match cycle.
    p_adc_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> $past(adc_enable));

    // R8: flag holds without a clear pulse.
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    // R10: zero control write drops the pin.
    p_zero_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && wr_data == 16'h0000) |=> !pin_o);
endmodule

bind cmp_event_unit cmp_event_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .flag_clr   (flag_clr),
    .adc_enable (adc_enable),
    .tmr_a_rst  (tmr_a_rst),
    .tmr_b_rst  (tmr_b_rst),
    .adc_start  (adc_start),
    .pin_o      (pin_o),
    .irq_flag   (irq_flag)
);

// File: tb/cmp_event_unit_test.sv
`timescale 1ns/1ps
// Directed bench for the compare channel: one task per scenario.
module cmp_event_unit_test;
    localparam logic [15:0] CMPV = 16'h1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] tmr_a_cnt = '0;
    logic [15:0] tmr_b_cnt = '0;
    logic        adc_enable = 1'b0;
    logic        pin_dir_out = 1'b0;
    logic        tmr_a_rst, tmr_b_rst, adc_start, pin_o, pin_oe, irq_flag;
    logic        f_a_rst, f_b_rst, f_adc, f_pin, f_oe, f_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmp_event_unit #(.SECOND_CH(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .flag_clr(flag_clr), .tmr_a_cnt(tmr_a_cnt),
        .tmr_b_cnt(tmr_b_cnt), .adc_enable(adc_enable),
        .pin_dir_out(pin_dir_out), .tmr_a_rst(tmr_a_rst),
        .tmr_b_rst(tmr_b_rst), .adc_start(adc_start), .pin_o(pin_o),
        .pin_oe(pin_oe), .irq_flag(irq_flag)
    );

    cmp_event_unit #(.SECOND_CH(1'b0)) uut_first (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .flag_clr(flag_clr), .tmr_a_cnt(tmr_a_cnt),
        .tmr_b_cnt(tmr_b_cnt), .adc_enable(adc_enable),
        .pin_dir_out(pin_dir_out), .tmr_a_rst(f_a_rst),
        .tmr_b_rst(f_b_rst), .adc_start(f_adc), .pin_o(f_pin),
        .pin_oe(f_oe), .irq_flag(f_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic adr, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = adr; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12", "pin_oe", pin_oe, 1'b0);
        chk("R12", "irq_flag", irq_flag, 1'b0);
        chk("R12", "tmr_a_rst", tmr_a_rst, 1'b0);
        chk("R12", "tmr_b_rst", tmr_b_rst, 1'b0);
        chk("R12", "adc_start", adc_start, 1'b0);
        pin_dir_out = 1'b1;
        #1;
        chk("R12", "latch low", pin_o, 1'b0);
    endtask

    task automatic t_set_and_select();
        wr(1'b1, CMPV);
        wr(1'b0, 16'h0008);
        tmr_a_cnt = CMPV - 1; tmr_b_cnt = CMPV;
        tick();
        chk("R1", "unselected timer B ignored", pin_o, 1'b0);
        chk("R1", "no flag from timer B", irq_flag, 1'b0);
        tmr_a_cnt = CMPV;
        tick();
        chk("R2", "set on match", pin_o, 1'b1);
        chk("R8", "flag on match", irq_flag, 1'b1);
        tmr_a_cnt = 16'h0000;
        tick();
        chk("R8", "flag held", irq_flag, 1'b1);
        clr_flag();
        chk("R8", "flag cleared", irq_flag, 1'b0);
    endtask

    task automatic t_clear();
        wr(1'b0, 16'h0009);
        tmr_a_cnt = CMPV;
        tick();
        chk("R3", "clear on match", pin_o, 1'b0);
        tmr_a_cnt = 16'h0000;
        tick();
        clr_flag();
    endtask

    task automatic t_toggle_stall();
        tmr_b_cnt = 16'h0000;
        wr(1'b0, 16'h0012);
        tick();
        tmr_b_cnt = CMPV;
        tick();
        chk("R4", "toggle to 1", pin_o, 1'b1);
        chk("R1", "timer B selected", irq_flag, 1'b1);
        repeat (3) tick();
        chk("R9", "stalled count no retrigger", pin_o, 1'b1);
        tmr_b_cnt = 16'h0000;
        tick();
        tmr_b_cnt = CMPV;
        tick();
        chk("R9", "rearmed toggle to 0", pin_o, 1'b0);
        tmr_b_cnt = 16'h0000;
        tick();
        clr_flag();
    endtask

    task automatic t_swint();
        wr(1'b0, 16'h001A);
        tmr_b_cnt = CMPV;
        tick();
        chk("R5", "latch unchanged", pin_o, 1'b0);
        chk("R5", "flag set", irq_flag, 1'b1);
        chk("R5", "no timer B reset", tmr_b_rst, 1'b0);
        tmr_b_cnt = 16'h0000;
        tick();
        clr_flag();
    endtask

    task automatic t_special();
        adc_enable = 1'b1;
        wr(1'b0, 16'h001B);
        tmr_b_cnt = CMPV;
        tick();
        chk("R6", "timer B reset pulse", tmr_b_rst, 1'b1);
        chk("R6", "timer A untouched", tmr_a_rst, 1'b0);
        chk("R6", "latch unchanged", pin_o, 1'b0);
        chk("R7", "adc start on second channel", adc_start, 1'b1);
        chk("R7", "no adc start on first channel", f_adc, 1'b0);
        chk("R6", "first channel resets too", f_b_rst, 1'b1);
        chk("R8", "flag set in event mode", irq_flag, 1'b1);
        tmr_b_cnt = 16'h0000;
        tick();
        chk("R6", "reset is one cycle", tmr_b_rst, 1'b0);
        chk("R7", "adc start one cycle", adc_start, 1'b0);
        adc_enable = 1'b0;
        wr(1'b0, 16'h000B);
        tmr_a_cnt = CMPV;
        tick();
        chk("R6", "timer A reset pulse", tmr_a_rst, 1'b1);
        chk("R6", "timer B quiet", tmr_b_rst, 1'b0);
        chk("R7", "adc gated off", adc_start, 1'b0);
        tmr_a_cnt = 16'h0000;
        tick();
        clr_flag();
    endtask

    task automatic t_clear_collision();
        wr(1'b0, 16'h0008);
        tmr_a_cnt = CMPV;
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        chk("R8", "match beats clear", irq_flag, 1'b1);
        tmr_a_cnt = 16'h0000;
        tick();
        clr_flag();
    endtask

    task automatic t_hidden_and_zero();
        wr(1'b0, 16'h0009);
        tmr_a_cnt = CMPV;
        tick();
        tmr_a_cnt = 16'h0000;
        pin_dir_out = 1'b0;
        wr(1'b0, 16'h0008);
        tmr_a_cnt = CMPV;
        tick();
        chk("R11", "pin off while input", pin_o, 1'b0);
        chk("R11", "oe follows dir", pin_oe, 1'b0);
        pin_dir_out = 1'b1;
        #1;
        chk("R11", "latch updated while input", pin_o, 1'b1);
        tmr_a_cnt = 16'h0000;
        tick();
        wr(1'b0, 16'h0002);
        chk("R10", "nonzero write keeps latch", pin_o, 1'b1);
        wr(1'b0, 16'h0000);
        chk("R10", "zero write clears latch", pin_o, 1'b0);
        clr_flag();
    endtask

    task automatic t_bad_code();
        wr(1'b0, 16'h0008);
        tmr_a_cnt = CMPV;
        tick();
        tmr_a_cnt = 16'h0000;
        tick();
        clr_flag();
        wr(1'b0, 16'h0005);
        tmr_a_cnt = CMPV;
        tick();
        chk("R10", "undefined code no action", pin_o, 1'b1);
        chk("R10", "undefined code no flag", irq_flag, 1'b0);
        tmr_a_cnt = 16'h0000;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_set_and_select();
        t_clear();
        t_toggle_stall();
        t_swint();
        t_special();
        t_clear_collision();
        t_hidden_and_zero();
        t_bad_code();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule